// File: doc/BRIEF.md
# Imprecise Bus-Fault NMI Latch

This block turns data-bus error responses into a pending non-maskable interrupt for the trap logic. A response counts as a fault when it is valid and carries an error. A tag on the response marks it as a load or a store, and that tag selects the cause code held for the trap logic: 1024 for a load and 1025 for a store. Only the first fault is held. Any fault that arrives while one is already pending is dropped. When the trap logic acknowledges handler entry, the pending state clears and the block can capture a new fault.

The request to the trap logic ignores the global interrupt enable and has no input for it. The request is held off while the core is in debug mode. It is also held off while the core is single-stepping with interrupts during stepping disabled. The pending flag is a separate output that stays visible throughout, so it can be mirrored into the debug status register. When the hold-off condition ends, the request appears in that same cycle.

Top module: `nmi_fault_latch`

## Requirements
- R1: After reset, nmiPending is 0, nmiReq is 0 and nmiCause is 0.
- R2: A response with respValid=1, respErr=1 and respIsStore=0 is captured at the next clock edge when nothing is pending. After that edge nmiPending=1 and nmiCause=1024.
- R3: A response with respValid=1, respErr=1 and respIsStore=1 is captured under the same conditions. After the edge nmiCause=1025.
- R4: A response with only one of respValid and respErr high captures nothing.
- R5: While nmiPending=1 and handlerAck=0, a new fault changes neither nmiCause nor nmiPending.
- R6: handlerAck=1 while pending clears nmiPending at the next edge, and nmiCause keeps its value. handlerAck=1 while nothing is pending has no effect.
- R7: A fault in the same cycle as a handlerAck that clears a pending NMI is captured as the new pending NMI, with its own cause code.
- R8: nmiReq equals nmiPending in the same cycle when dbgMode=0 and no masked single-step is active.
- R9: dbgMode=1 forces nmiReq to 0 while nmiPending keeps its value. nmiReq rises in the first cycle after dbgMode falls.
- R10: stepActive=1 with stepIrqEn=0 forces nmiReq to 0. With stepIrqEn=1, single-stepping does not mask the request.
- R11: Faults are still captured while the request is held off, and nmiPending reports them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| respValid | input | 1 | Data-bus response valid |
| respErr | input | 1 | Data-bus response carries an error |
| respIsStore | input | 1 | 1 marks the response as a store, 0 as a load |
| handlerAck | input | 1 | Trap logic has entered the NMI handler |
| dbgMode | input | 1 | Core is in debug mode |
| stepActive | input | 1 | Core is single-stepping |
| stepIrqEn | input | 1 | Interrupts allowed during single-step |
| nmiReq | output | 1 | NMI request to the trap logic |
| nmiCause | output | 11 | Cause code of the held fault |
| nmiPending | output | 1 | NMI held and not yet taken, for the debug status register |

## Verification
The hardest case to reach is a handler acknowledge that lands in the same cycle as a fresh fault. In that case the clear and the capture compete for the pending flag. The stimulus first holds a store fault pending. It then drives the acknowledge and a load fault together in one cycle and expects the load cause code to take the place of the store code. A second hard case is a fault captured while debug mode holds the request off. The stimulus then lowers debug mode and expects the request in that same cycle.

// File: rtl/nmi_latch_pkg.sv
package nmi_latch_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capture;       // load a new fault into the holding register
    logic captureStore;  // the captured fault is a store
    logic clear;         // handler entered, drop pending state
  } nmiStrobe_t;
endpackage

// File: rtl/nmi_latch_ctrl.sv
module nmi_latch_ctrl
  import nmi_latch_pkg::*;
(
  input  logic       respValid,
  input  logic       respErr,
  input  logic       respIsStore,
  input  logic       handlerAck,
  input  logic       dbgMode,
  input  logic       stepActive,
  input  logic       stepIrqEn,
  input  logic       pendingQ,
  output nmiStrobe_t strobes,
  output logic       nmiReq
);
  logic faultSeen;
  logic slotFree;
  logic holdOff;

  always_comb begin
    faultSeen            = respValid & respErr;
    // the slot opens again on the cycle the handler is entered
    slotFree             = ~pendingQ | handlerAck;
    strobes.clear        = handlerAck & pendingQ;
    strobes.capture      = faultSeen & slotFree;
    strobes.captureStore = faultSeen & slotFree & respIsStore;
    holdOff              = dbgMode | (stepActive & ~stepIrqEn);
    nmiReq               = pendingQ & ~holdOff;
  end
endmodule

// File: rtl/nmi_latch_dp.sv
module nmi_latch_dp
  import nmi_latch_pkg::*;
#(
  parameter int LOAD_CODE  = 1024,
  parameter int STORE_CODE = 1025,
  parameter int CAUSE_W    = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  nmiStrobe_t         strobes,
  output logic               pendingQ,
  output logic [CAUSE_W-1:0] causeQ
);
  localparam logic [CAUSE_W-1:0] LoadVal  = CAUSE_W'(LOAD_CODE);
  localparam logic [CAUSE_W-1:0] StoreVal = CAUSE_W'(STORE_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      causeQ   <= '0;
    end else if (strobes.capture) begin
      pendingQ <= 1'b1;
      causeQ   <= strobes.captureStore ? StoreVal : LoadVal;
    end else if (strobes.clear) begin
      pendingQ <= 1'b0;
    end
  end

  // R2
  capture_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> pendingQ);

  // R5
  first_fault_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ && !strobes.clear && !strobes.capture |=> pendingQ && $stable(causeQ));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear && !strobes.capture |=> !pendingQ && $stable(causeQ));
endmodule

// File: rtl/nmi_fault_latch.sv
module nmi_fault_latch
  import nmi_latch_pkg::*;
#(
  parameter int LOAD_CODE  = 1024,
  parameter int STORE_CODE = 1025,
  parameter int CAUSE_W    = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               respValid,
  input  logic               respErr,
  input  logic               respIsStore,
  input  logic               handlerAck,
  input  logic               dbgMode,
  input  logic               stepActive,
  input  logic               stepIrqEn,
  output logic               nmiReq,
  output logic [CAUSE_W-1:0] nmiCause,
  output logic               nmiPending
);
  nmiStrobe_t strobes;
  logic       pendingQ;

  nmi_latch_ctrl u_ctrl (
    .respValid  (respValid),
    .respErr    (respErr),
    .respIsStore(respIsStore),
    .handlerAck (handlerAck),
    .dbgMode    (dbgMode),
    .stepActive (stepActive),
    .stepIrqEn  (stepIrqEn),
    .pendingQ   (pendingQ),
    .strobes    (strobes),
    .nmiReq     (nmiReq)
  );

  nmi_latch_dp #(
    .LOAD_CODE (LOAD_CODE),
    .STORE_CODE(STORE_CODE),
    .CAUSE_W   (CAUSE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pendingQ(pendingQ),
    .causeQ  (nmiCause)
  );

  assign nmiPending = pendingQ;

  // R8
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> nmiPending);

  // R9
  debug_holds_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgMode |-> !nmiReq);

  // R10
  step_holds_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepActive && !stepIrqEn |-> !nmiReq);

  // R9
  release_on_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiPending && !dbgMode && !(stepActive && !stepIrqEn) |-> nmiReq);
endmodule

// File: tb/nmi_fault_latch_bench.sv
module nmi_fault_latch_bench;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic respValid = 1'b0, respErr = 1'b0, respIsStore = 1'b0, handlerAck = 1'b0;
  logic dbgMode = 1'b0, stepActive = 1'b0, stepIrqEn = 1'b0;
  logic nmiReq, nmiPending;
  logic [CW-1:0] nmiCause;

  always #10 clk = ~clk;  // 50 MHz

  nmi_fault_latch u_nmi_fault_latch (
    .clk(clk), .rstN(rstN), .respValid(respValid), .respErr(respErr),
    .respIsStore(respIsStore), .handlerAck(handlerAck), .dbgMode(dbgMode),
    .stepActive(stepActive), .stepIrqEn(stepIrqEn), .nmiReq(nmiReq),
    .nmiCause(nmiCause), .nmiPending(nmiPending)
  );

  typedef struct {
    logic          pend;
    logic [CW-1:0] cause;
    logic          req;
    string         tag;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  logic mPend = 1'b0;
  logic [CW-1:0] mCause = '0;

  task automatic compare(input item_t e);
    compared++;
    if (nmiPending !== e.pend || nmiCause !== e.cause || nmiReq !== e.req) begin
      mismatched++;
      $display("FAIL %s: got pend=%b cause=%0d req=%b, expected pend=%b cause=%0d req=%b",
               e.tag, nmiPending, nmiCause, nmiReq, e.pend, e.cause, e.req);
    end
  endtask

  // driver: one cycle of stimulus plus its predicted result
  task automatic cyc(input logic v, input logic e, input logic st, input logic ack,
                     input logic dbg, input logic stp, input logic sie, input string tag);
    item_t it;
    logic nPend;
    @(negedge clk);
    respValid = v; respErr = e; respIsStore = st; handlerAck = ack;
    dbgMode = dbg; stepActive = stp; stepIrqEn = sie;
    nPend = mPend && !ack;
    if (v && e && (!mPend || ack)) begin
      nPend  = 1'b1;
      mCause = st ? CW'(1025) : CW'(1024);
    end
    mPend    = nPend;
    it.pend  = mPend;
    it.cause = mCause;
    it.req   = mPend && !dbg && !(stp && !sie);
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    item_t r;
    repeat (3) @(posedge clk);
    #5;
    r.pend = 1'b0; r.cause = '0; r.req = 1'b0; r.tag = "R1 reset";
    compare(r);
    @(negedge clk) rstN = 1'b1;
    cyc(0,0,0,0,0,0,0, "R1 idle after reset");
    cyc(1,0,0,0,0,0,0, "R4 valid without error");
    cyc(0,1,1,0,0,0,0, "R4 error without valid");
    cyc(1,1,0,0,0,0,0, "R2 load fault");
    cyc(0,0,0,0,0,0,0, "R8 request follows pending");
    cyc(1,1,1,0,0,0,0, "R5 store fault dropped");
    cyc(1,1,0,0,1,0,0, "R9 debug holds request");
    cyc(0,0,0,0,0,0,0, "R9 release on debug exit");
    cyc(0,0,0,0,0,1,0, "R10 step without irq");
    cyc(0,0,0,0,0,1,1, "R10 step with irq");
    cyc(0,0,0,1,0,0,0, "R6 ack clears");
    cyc(0,0,0,1,0,0,0, "R6 ack with nothing pending");
    cyc(1,1,1,0,1,0,0, "R11 store captured in debug");
    cyc(0,0,0,0,1,0,0, "R11 pending visible in debug");
    cyc(0,0,0,0,0,0,0, "R3 store cause released");
    cyc(1,1,0,1,0,0,0, "R7 ack with new load fault");
    cyc(0,0,0,1,0,1,0, "R6 ack during masked step");
    cyc(1,1,1,0,0,1,0, "R11 store captured in step");
    cyc(0,0,0,0,0,0,0, "R3 store cause after step");
    cyc(0,0,0,0,0,0,0, "R8 idle");
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule